// File: doc/BRIEF.md
# Bus Width Conversion Adapter

This block joins an application port that always moves 32-bit words to a memory datapath that runs either 32 or 16 bits wide. A single run-time mode input selects the width. In the full-width setting every request, write and read signal crosses unchanged, except that read data goes through one register stage. In the half-width setting the block changes the units of each request so that the memory side counts 16-bit beats. It also serialises each 32-bit write word into two half-word beats and joins pairs of returning half-word read beats into whole words.

Requests cross without a register. Address and length are rescaled when the half-width setting is selected. Valid, the end-of-transfer flag and the acknowledge pass straight through. On the write side the memory path pulls data with a per-beat advance strobe. The adapter passes that strobe on to the application only once a full word has been consumed. On the read side one register stage drives the valid strobe and the data.

Top module: `bus_width_adapter`

## Requirements
- R1: With `narrow_mode` = 0, `mem_req_addr` equals `app_req_addr` with a 0 added above its top bit, and `mem_req_len` equals `app_req_len` with a 0 added above its top bit. Both follow the inputs in the same cycle.
- R2: With `narrow_mode` = 1, `mem_req_addr` is `app_req_addr` with one extra bit 0 appended below its least significant bit. `mem_req_len` is twice `app_req_len` (a 0 appended below its LSB), so the largest length of 511 words becomes 1022 beats.
- R3: In both modes `mem_req_valid` follows `app_req_valid`, `mem_req_last` follows `app_req_last`, and `app_req_ack` follows `mem_req_ack`, all in the same cycle.
- R4: With `narrow_mode` = 0, `mem_wr_data`, `mem_wr_mask_n` and `app_wr_next` equal `app_wr_data`, `app_wr_mask_n` and `mem_wr_next` in the same cycle.
- R5: With `narrow_mode` = 1, `mem_wr_data[31:16]` is 0 and `mem_wr_mask_n[3:2]` is 2'b11, because byte enables are active low and one bit covers one byte. The first beat of a word carries `app_wr_data[15:0]` with `app_wr_mask_n[1:0]`. The second beat carries `app_wr_data[31:16]` with `app_wr_mask_n[3:2]`.
- R6: With `narrow_mode` = 1, `app_wr_next` is high only together with every second `mem_wr_next` pulse. Each such `mem_wr_next` pulse moves the beat selection to the next half.
- R7: With `narrow_mode` = 0, a cycle with `mem_rd_valid` high gives `app_rd_valid` high with `app_rd_data` equal to that cycle's `mem_rd_data` one cycle later. A cycle without one gives `app_rd_valid` low one cycle later.
- R8: With `narrow_mode` = 1, the first read beat of a pair raises no valid. One cycle after the second beat, `app_rd_valid` is high and `app_rd_data` is {second beat[15:0], first beat[15:0]}.
- R9: Reset (`rst_n` low, asynchronous) forces `app_rd_valid` low. It also clears the write and read half-selection, so the first write beat and the first read beat after reset are low halves.
- R10: With `narrow_mode` = 1, bits [31:16] of `mem_rd_data` have no effect on `app_rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| narrow_mode | input | 1 | 0: 32-bit memory path, 1: 16-bit memory path |
| app_req_valid | input | 1 | Application request valid |
| app_req_addr | input | 30 | Request address in 32-bit words |
| app_req_len | input | 9 | Request length in 32-bit words |
| app_req_last | input | 1 | Final request of a transfer series |
| app_req_ack | output | 1 | Request accepted |
| mem_req_valid | output | 1 | Request valid to memory side |
| mem_req_addr | output | 31 | Rescaled request address |
| mem_req_len | output | 10 | Rescaled request length in memory beats |
| mem_req_last | output | 1 | Final-request flag to memory side |
| mem_req_ack | input | 1 | Memory side accepted the request |
| app_wr_data | input | 32 | Application write word |
| app_wr_mask_n | input | 4 | Active-low byte enables of the write word |
| app_wr_next | output | 1 | Application may present the next write word |
| mem_wr_data | output | 32 | Write beat to memory side |
| mem_wr_mask_n | output | 4 | Active-low byte enables of the write beat |
| mem_wr_next | input | 1 | Memory side consumed the current write beat |
| mem_rd_data | input | 32 | Read beat from memory side |
| mem_rd_valid | input | 1 | Read beat valid |
| app_rd_data | output | 32 | Read word to application |
| app_rd_valid | output | 1 | Read word valid |

## Verification
The bench goes after the half ordering. A design that swaps the halves or the mask pairs would send the upper half first, or put the wrong enable bits on the narrow lane. It drives the largest address and length values, where a wrong shift would drop the top address bit or wrap the doubled length. It checks that the application's advance strobe appears only with the second beat; a design that pulses it each beat would make the application skip every other word. It feeds read beats whose upper lanes carry garbage, and it resets halfway through a read pair. A design that packs the wrong lanes, or keeps a stale low half across reset, returns words made from the wrong data.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  typedef enum logic {
    PATH_FULL = 1'b0,
    PATH_HALF = 1'b1
  } path_mode_e;
endpackage

// File: rtl/bwc_req_scale.sv
module bwc_req_scale
  import bwc_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int LEN_W  = 9
) (
  input  path_mode_e        mode,
  input  logic              a_valid,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [LEN_W-1:0]  a_len,
  input  logic              a_last,
  output logic              a_ack,
  output logic              m_valid,
  output logic [ADDR_W:0]   m_addr,
  output logic [LEN_W:0]    m_len,
  output logic              m_last,
  input  logic              m_ack
);
  // Request handshake flags cross unchanged in both modes.
  assign m_valid = a_valid;
  assign m_last  = a_last;
  assign a_ack   = m_ack;

  // Units change from words to half-words on the narrow path.
  always_comb begin
    if (mode == PATH_HALF) begin
      m_addr = {a_addr, 1'b0};
      m_len  = {a_len, 1'b0};
    end else begin
      m_addr = {1'b0, a_addr};
      m_len  = {1'b0, a_len};
    end
  end
endmodule

// File: rtl/bwc_wr_split.sv
module bwc_wr_split
  import bwc_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  path_mode_e          mode,
  input  logic [WORD_W-1:0]   a_data,
  input  logic [WORD_W/8-1:0] a_mask_n,
  output logic                a_next,
  output logic [WORD_W-1:0]   m_data,
  output logic [WORD_W/8-1:0] m_mask_n,
  input  logic                m_next
);
  localparam int HALF_W  = WORD_W / 2;
  localparam int MASK_W  = WORD_W / 8;
  localparam int HMASK_W = MASK_W / 2;

  logic hi_sel_q, hi_sel_d;

  always_comb begin
    hi_sel_d = hi_sel_q;
    if (mode != PATH_HALF)
      hi_sel_d = 1'b0;
    else if (m_next)
      hi_sel_d = ~hi_sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_sel_q <= 1'b0;
    else        hi_sel_q <= hi_sel_d;
  end

  always_comb begin
    if (mode == PATH_HALF) begin
      m_data   = '0;
      m_mask_n = '1;
      if (hi_sel_q) begin
        m_data[HALF_W-1:0]    = a_data[WORD_W-1:HALF_W];
        m_mask_n[HMASK_W-1:0] = a_mask_n[MASK_W-1:HMASK_W];
      end else begin
        m_data[HALF_W-1:0]    = a_data[HALF_W-1:0];
        m_mask_n[HMASK_W-1:0] = a_mask_n[HMASK_W-1:0];
      end
      a_next = m_next & hi_sel_q;
    end else begin
      m_data   = a_data;
      m_mask_n = a_mask_n;
      a_next   = m_next;
    end
  end

  // R6: a consumed low beat moves to the high half
  assert_pace_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PATH_HALF && m_next && !a_next) |=> hi_sel_q);
  // R6: a word handed back to the application restarts at the low half
  assert_pace_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PATH_HALF && a_next) |=> !hi_sel_q);
endmodule

// File: rtl/bwc_rd_pack.sv
module bwc_rd_pack
  import bwc_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  path_mode_e        mode,
  input  logic [WORD_W-1:0] m_data,
  input  logic              m_valid,
  output logic [WORD_W-1:0] a_data,
  output logic              a_valid
);
  localparam int HALF_W = WORD_W / 2;

  logic [HALF_W-1:0] lo_q, lo_d;
  logic              have_lo_q, have_lo_d;
  logic [WORD_W-1:0] out_q, out_d;
  logic              vld_q, vld_d;

  always_comb begin
    lo_d      = lo_q;
    have_lo_d = have_lo_q;
    out_d     = out_q;
    vld_d     = 1'b0;
    if (mode != PATH_HALF) begin
      have_lo_d = 1'b0;
      if (m_valid) begin
        out_d = m_data;
        vld_d = 1'b1;
      end
    end else if (m_valid) begin
      if (!have_lo_q) begin
        lo_d      = m_data[HALF_W-1:0];
        have_lo_d = 1'b1;
      end else begin
        out_d     = {m_data[HALF_W-1:0], lo_q};
        vld_d     = 1'b1;
        have_lo_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q      <= '0;
      have_lo_q <= 1'b0;
      out_q     <= '0;
      vld_q     <= 1'b0;
    end else begin
      if (m_valid) lo_q <= lo_d;
      have_lo_q <= have_lo_d;
      if (vld_d) out_q <= out_d;
      vld_q <= vld_d;
    end
  end

  assign a_data  = out_q;
  assign a_valid = vld_q;

  // R7: full-width beat appears one cycle later, data intact
  assert_full_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PATH_FULL && m_valid) |=> (a_valid && a_data == $past(m_data)));
  // R8: the first beat of a pair never raises valid
  assert_first_beat_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PATH_HALF && m_valid && !have_lo_q) |=> !a_valid);
  // R9: a cycle spent in reset leaves valid low
  assert_reset_quiet_R9: assert property (@(posedge clk)
    $past(!rst_n) |-> !a_valid);
endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
  import bwc_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int LEN_W  = 9,
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                narrow_mode,
  input  logic                app_req_valid,
  input  logic [ADDR_W-1:0]   app_req_addr,
  input  logic [LEN_W-1:0]    app_req_len,
  input  logic                app_req_last,
  output logic                app_req_ack,
  output logic                mem_req_valid,
  output logic [ADDR_W:0]     mem_req_addr,
  output logic [LEN_W:0]      mem_req_len,
  output logic                mem_req_last,
  input  logic                mem_req_ack,
  input  logic [WORD_W-1:0]   app_wr_data,
  input  logic [WORD_W/8-1:0] app_wr_mask_n,
  output logic                app_wr_next,
  output logic [WORD_W-1:0]   mem_wr_data,
  output logic [WORD_W/8-1:0] mem_wr_mask_n,
  input  logic                mem_wr_next,
  input  logic [WORD_W-1:0]   mem_rd_data,
  input  logic                mem_rd_valid,
  output logic [WORD_W-1:0]   app_rd_data,
  output logic                app_rd_valid
);
  path_mode_e mode;
  assign mode = path_mode_e'(narrow_mode);

  bwc_req_scale #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_req (
    .mode    (mode),
    .a_valid (app_req_valid),
    .a_addr  (app_req_addr),
    .a_len   (app_req_len),
    .a_last  (app_req_last),
    .a_ack   (app_req_ack),
    .m_valid (mem_req_valid),
    .m_addr  (mem_req_addr),
    .m_len   (mem_req_len),
    .m_last  (mem_req_last),
    .m_ack   (mem_req_ack)
  );

  bwc_wr_split #(.WORD_W(WORD_W)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .a_data   (app_wr_data),
    .a_mask_n (app_wr_mask_n),
    .a_next   (app_wr_next),
    .m_data   (mem_wr_data),
    .m_mask_n (mem_wr_mask_n),
    .m_next   (mem_wr_next)
  );

  bwc_rd_pack #(.WORD_W(WORD_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .m_data  (mem_rd_data),
    .m_valid (mem_rd_valid),
    .a_data  (app_rd_data),
    .a_valid (app_rd_valid)
  );
endmodule

// File: tb/sim_bus_width_adapter.sv
module sim_bus_width_adapter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        narrow_mode;
  logic        app_req_valid, app_req_last, mem_req_ack;
  logic [29:0] app_req_addr;
  logic [8:0]  app_req_len;
  logic        app_req_ack, mem_req_valid, mem_req_last;
  logic [30:0] mem_req_addr;
  logic [9:0]  mem_req_len;
  logic [31:0] app_wr_data, mem_wr_data, mem_rd_data, app_rd_data;
  logic [3:0]  app_wr_mask_n, mem_wr_mask_n;
  logic        app_wr_next, mem_wr_next, mem_rd_valid, app_rd_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  bus_width_adapter u0 (
    .clk(clk), .rst_n(rst_n), .narrow_mode(narrow_mode),
    .app_req_valid(app_req_valid), .app_req_addr(app_req_addr),
    .app_req_len(app_req_len), .app_req_last(app_req_last),
    .app_req_ack(app_req_ack), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len),
    .mem_req_last(mem_req_last), .mem_req_ack(mem_req_ack),
    .app_wr_data(app_wr_data), .app_wr_mask_n(app_wr_mask_n),
    .app_wr_next(app_wr_next), .mem_wr_data(mem_wr_data),
    .mem_wr_mask_n(mem_wr_mask_n), .mem_wr_next(mem_wr_next),
    .mem_rd_data(mem_rd_data), .mem_rd_valid(mem_rd_valid),
    .app_rd_data(app_rd_data), .app_rd_valid(app_rd_valid)
  );

  typedef struct packed {
    logic        mode;
    logic [29:0] addr;
    logic [8:0]  len;
    logic [30:0] exp_addr;
    logic [9:0]  exp_len;
  } vec_t;

  localparam vec_t [0:5] VECS = '{
    '{1'b0, 30'h0000_1234, 9'd8,    31'h0000_1234, 10'd8},
    '{1'b1, 30'h0000_1234, 9'd8,    31'h0000_2468, 10'd16},
    '{1'b1, 30'h3FFF_FFFF, 9'h1FF,  31'h7FFF_FFFE, 10'h3FE},
    '{1'b0, 30'h3FFF_FFFF, 9'h1FF,  31'h3FFF_FFFF, 10'h1FF},
    '{1'b1, 30'h0000_0000, 9'd1,    31'h0000_0000, 10'd2},
    '{1'b0, 30'h2AAA_AAAA, 9'd0,    31'h2AAA_AAAA, 10'd0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; narrow_mode = 1'b0;
    app_req_valid = 0; app_req_last = 0; mem_req_ack = 0;
    app_req_addr = '0; app_req_len = '0;
    app_wr_data = '0; app_wr_mask_n = '1; mem_wr_next = 0;
    mem_rd_data = '0; mem_rd_valid = 0;
    repeat (3) @(negedge clk);
    chk("R9 reset valid", {63'd0, app_rd_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Request path from the vector table
    for (int i = 0; i < 6; i++) begin
      narrow_mode   = VECS[i].mode;
      app_req_addr  = VECS[i].addr;
      app_req_len   = VECS[i].len;
      app_req_valid = i[0];
      app_req_last  = i[1];
      mem_req_ack   = ~i[0];
      #1;
      chk(VECS[i].mode ? "R2 addr" : "R1 addr", {33'd0, mem_req_addr}, {33'd0, VECS[i].exp_addr});
      chk(VECS[i].mode ? "R2 len" : "R1 len", {54'd0, mem_req_len}, {54'd0, VECS[i].exp_len});
      chk("R3 flags", {61'd0, mem_req_valid, mem_req_last, app_req_ack},
          {61'd0, i[0], i[1], ~i[0]});
      @(negedge clk);
    end

    // R4: full-width write pass-through
    narrow_mode = 1'b0; app_wr_data = 32'h1122_3344; app_wr_mask_n = 4'b1010;
    mem_wr_next = 1'b1; #1;
    chk("R4 data", {32'd0, mem_wr_data}, {32'd0, 32'h1122_3344});
    chk("R4 mask", {60'd0, mem_wr_mask_n}, {60'd0, 4'b1010});
    chk("R4 next", {63'd0, app_wr_next}, 64'd1);
    @(negedge clk);
    mem_wr_next = 1'b0;
    @(negedge clk);

    // R5/R6: half-width write, two words
    narrow_mode = 1'b1; app_wr_data = 32'hA1B2_C3D4; app_wr_mask_n = 4'b0110; #1;
    chk("R5 low beat", {32'd0, mem_wr_data}, {32'd0, 32'h0000_C3D4});
    chk("R5 low mask", {60'd0, mem_wr_mask_n}, {60'd0, 4'b1110});
    mem_wr_next = 1'b1; #1;
    chk("R6 no next on low", {63'd0, app_wr_next}, 64'd0);
    @(negedge clk);
    chk("R5 high beat", {32'd0, mem_wr_data}, {32'd0, 32'h0000_A1B2});
    chk("R5 high mask", {60'd0, mem_wr_mask_n}, {60'd0, 4'b1101});
    chk("R6 next on high", {63'd0, app_wr_next}, 64'd1);
    @(negedge clk);
    app_wr_data = 32'h5566_7788; app_wr_mask_n = 4'b1001; #1;
    chk("R6 word two low", {32'd0, mem_wr_data}, {32'd0, 32'h0000_7788});
    chk("R6 word two no next", {63'd0, app_wr_next}, 64'd0);
    mem_wr_next = 1'b0;
    @(negedge clk);
    chk("R6 held without strobe", {32'd0, mem_wr_data}, {32'd0, 32'h0000_7788});
    mem_wr_next = 1'b1;
    @(negedge clk);
    chk("R6 word two high", {32'd0, mem_wr_data}, {32'd0, 32'h0000_5566});
    chk("R5 word two high mask", {60'd0, mem_wr_mask_n}, {60'd0, 4'b1110});
    chk("R6 word two next", {63'd0, app_wr_next}, 64'd1);
    @(negedge clk);
    mem_wr_next = 1'b0;

    // R7: full-width read
    narrow_mode = 1'b0;
    @(negedge clk);
    mem_rd_valid = 1'b1; mem_rd_data = 32'hDEAD_BEEF;
    @(negedge clk);
    mem_rd_valid = 1'b0; mem_rd_data = 32'h0;
    chk("R7 valid", {63'd0, app_rd_valid}, 64'd1);
    chk("R7 data", {32'd0, app_rd_data}, {32'd0, 32'hDEAD_BEEF});
    @(negedge clk);
    chk("R7 idle", {63'd0, app_rd_valid}, 64'd0);

    // R8/R10: half-width read, upper lanes carry garbage
    narrow_mode = 1'b1;
    mem_rd_valid = 1'b1; mem_rd_data = 32'hFFFF_1111;
    @(negedge clk);
    chk("R8 first beat quiet", {63'd0, app_rd_valid}, 64'd0);
    mem_rd_data = 32'h5555_2222;
    @(negedge clk);
    mem_rd_valid = 1'b0;
    chk("R8 pair valid", {63'd0, app_rd_valid}, 64'd1);
    chk("R10 pair data", {32'd0, app_rd_data}, {32'd0, 32'h2222_1111});
    @(negedge clk);
    chk("R8 single pulse", {63'd0, app_rd_valid}, 64'd0);

    // R9: reset in the middle of a read pair and a write word
    mem_rd_valid = 1'b1; mem_rd_data = 32'h0000_9999; mem_wr_next = 1'b1;
    @(negedge clk);
    mem_rd_valid = 1'b0; mem_wr_next = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    app_wr_data = 32'hCAFE_F00D; app_wr_mask_n = 4'b0011; #1;
    chk("R9 write restarts low", {32'd0, mem_wr_data}, {32'd0, 32'h0000_F00D});
    mem_rd_valid = 1'b1; mem_rd_data = 32'h1234_0A0A;
    @(negedge clk);
    chk("R9 first beat after reset quiet", {63'd0, app_rd_valid}, 64'd0);
    mem_rd_data = 32'h0000_0B0B;
    @(negedge clk);
    mem_rd_valid = 1'b0;
    chk("R9 pair after reset", {32'd0, app_rd_data}, {32'd0, 32'h0B0B_0A0A});
    chk("R9 pair valid after reset", {63'd0, app_rd_valid}, 64'd1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule